// File: doc/BRIEF.md
# CAS-Before-RAS Refresh Sequencer

This block keeps four DRAM banks refreshed. A free-running interval timer raises a refresh request every `reload_val + 1` clocks. The request stays pending until a memory arbiter grants it and no ordinary transfer is in flight. The block then runs a CAS-before-RAS refresh on the bank strobes, closes every row for a programmed precharge time, and pulses `done`. The write-enable strobe belongs to refresh alone and is held high throughout.

Refresh runs in one of two ways. In simultaneous mode all four banks refresh at once. In staggered mode the even banks refresh first and the odd banks second, which halves the peak current and doubles the length of the strobe activity. The RAS pulse width, the precharge time and the mode are captured when a sequence starts, so software may change them at any time. Boot code can load a short interval to get its first few refreshes quickly, then load the normal interval. A smaller value takes effect at once.

The `req`/`grant` pair works like a valid/ready handshake. `req` is the valid. It cannot be withdrawn and no new tick is counted while it is pending. The arbiter may hold `grant` low for as long as it needs to. A sequence starts only in a cycle where `req`, `grant` and not `xact_busy` are all true. The arbiter may hold `grant` high continuously, and the block takes a pending request as soon as it can.

Top module: `cbr_refresh_seq`

## Requirements
- R1: The interval timer raises `req` at the clock edge that is `reload_val + 1` edges after reset release, and then every `reload_val + 1` clocks. A reload value below the present count takes effect at once.
- R2: `req` is sticky. It falls only at the edge that ends a cycle with `done` high. If a timer tick lands on that same edge, `req` stays high.
- R3: A sequence (`busy` high) begins one clock after a cycle with `req`, `grant` and not `xact_busy` all high. While `xact_busy` is high no strobe moves, even with `grant` high.
- R4: Every refresh phase opens with one cycle of `cas_n` = 4'b0000 and `ras_n` = 4'b1111. This is followed by the RAS cycles, with `cas_n` still 4'b0000.
- R5: With `stagger_en` = 0, one phase drives `ras_n` = 4'b0000 for the RAS width. `busy` then lasts 1 + width + precharge cycles.
- R6: With `stagger_en` = 1, the first phase drives `ras_n` = 4'b1010 (banks 0 and 2 low) and the second drives 4'b0101 (banks 1 and 3 low). Each phase is 1 + width cycles, followed by the precharge.
- R7: After the last RAS cycle, all strobes stay high for the precharge time with `busy` high. `done` is high in the last of these cycles only.
- R8: `we_n` is 1 in every cycle.
- R9: A `ras_width` or `pre_time` of 0 behaves as 1.
- R10: `stagger_en`, `ras_width` and `pre_time` are sampled at the start of a sequence. Changing them during a sequence has no effect on it.
- R11: Reset forces all RAS and CAS strobes high, `we_n` high, `req`, `busy` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reload_val | input | IW (16) | Interval between refresh requests, minus one |
| stagger_en | input | 1 | 1 = refresh bank pairs in turn, 0 = all banks together |
| ras_width | input | TW (4) | RAS low time per phase in clocks (0 acts as 1) |
| pre_time | input | TW (4) | Precharge time after refresh in clocks (0 acts as 1) |
| xact_busy | input | 1 | An ordinary memory transfer has not reached its end state |
| grant | input | 1 | Arbiter grants the refresh request |
| req | output | 1 | Refresh request pending |
| busy | output | 1 | Refresh sequence in progress, precharge included |
| done | output | 1 | Last precharge cycle of the sequence |
| ras_n | output | NBANK (4) | Per-bank RAS strobes, active low |
| cas_n | output | NBANK (4) | Per-bank CAS strobes, active low |
| we_n | output | 1 | Refresh write enable, held high |

## Verification
The interval tick and the completion of a sequence can land on the same edge: one would set the request and the other would clear it. The bench forces this from reset by choosing reload = width + precharge + 1 with `grant` held high. The first request then starts a sequence whose `done` edge coincides exactly with the second tick. The outcome is judged at the ports: the cycle after `done` must show `req` still high with `busy` low, so that the new request is not lost.

// File: rtl/cbr_refresh_pkg.sv
`timescale 1ns/1ps
package cbr_refresh_pkg;
  typedef enum logic [1:0] {
    RF_IDLE,
    RF_LEAD,
    RF_RAS,
    RF_PRE
  } rf_state_e;
endpackage

// File: rtl/rf_interval_timer.sv
`timescale 1ns/1ps
module rf_interval_timer #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] reload_val,
  output logic          tick
);
  logic [IW-1:0] cnt;

  // terminal count uses >= so that a shrinking reload value applies at once
  assign tick = (cnt >= reload_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rf_request_flag.sv
`timescale 1ns/1ps
module rf_request_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  output logic req
);
  // a new tick outranks the clear from a finishing sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     req <= 1'b0;
    else if (tick)  req <= 1'b1;
    else if (clear) req <= 1'b0;
  end
endmodule

// File: rtl/rf_sequencer.sv
`timescale 1ns/1ps
module rf_sequencer
  import cbr_refresh_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ok,
  input  logic          stagger_en,
  input  logic [TW-1:0] ras_width,
  input  logic [TW-1:0] pre_time,
  output rf_state_e     st,
  output logic          phase,
  output logic          stag_q,
  output logic          done
);
  logic [TW-1:0] tcnt, w_q, p_q, w_eff, p_eff;

  assign w_eff = (ras_width == '0) ? TW'(1) : ras_width;
  assign p_eff = (pre_time  == '0) ? TW'(1) : pre_time;
  assign done  = (st == RF_PRE) && (tcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RF_IDLE;
      phase  <= 1'b0;
      stag_q <= 1'b0;
      tcnt   <= '0;
      w_q    <= TW'(1);
      p_q    <= TW'(1);
    end else begin
      unique case (st)
        RF_IDLE: if (start_ok) begin
          st     <= RF_LEAD;
          phase  <= 1'b0;
          stag_q <= stagger_en;
          w_q    <= w_eff;
          p_q    <= p_eff;
        end
        RF_LEAD: begin
          st   <= RF_RAS;
          tcnt <= w_q - 1'b1;
        end
        RF_RAS: begin
          if (tcnt != '0) begin
            tcnt <= tcnt - 1'b1;
          end else if (stag_q && !phase) begin
            st    <= RF_LEAD;
            phase <= 1'b1;
          end else begin
            st   <= RF_PRE;
            tcnt <= p_q - 1'b1;
          end
        end
        RF_PRE: begin
          if (tcnt != '0) tcnt <= tcnt - 1'b1;
          else            st   <= RF_IDLE;
        end
        default: st <= RF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rf_strobe_decode.sv
`timescale 1ns/1ps
module rf_strobe_decode
  import cbr_refresh_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  rf_state_e        st,
  input  logic             phase,
  input  logic             stag_q,
  output logic [NBANK-1:0] ras_n,
  output logic [NBANK-1:0] cas_n,
  output logic             we_n
);
  logic cas_on;
  assign cas_on = (st == RF_LEAD) || (st == RF_RAS);
  assign cas_n  = {NBANK{~cas_on}};
  assign we_n   = 1'b1;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    // even banks form the first staggered pair, odd banks the second
    localparam logic ODD = ((b % 2) == 1);
    logic sel;
    assign sel      = !stag_q || (phase == ODD);
    assign ras_n[b] = !((st == RF_RAS) && sel);
  end
endmodule

// File: rtl/cbr_refresh_seq.sv
`timescale 1ns/1ps
module cbr_refresh_seq
  import cbr_refresh_pkg::*;
#(
  parameter int IW    = 16,
  parameter int TW    = 4,
  parameter int NBANK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    reload_val,
  input  logic             stagger_en,
  input  logic [TW-1:0]    ras_width,
  input  logic [TW-1:0]    pre_time,
  input  logic             xact_busy,
  input  logic             grant,
  output logic             req,
  output logic             busy,
  output logic             done,
  output logic [NBANK-1:0] ras_n,
  output logic [NBANK-1:0] cas_n,
  output logic             we_n
);
  logic      tick, phase, stag_q, start_ok;
  rf_state_e st;

  assign start_ok = req && grant && !xact_busy;
  assign busy     = (st != RF_IDLE);

  rf_interval_timer #(.IW(IW)) u_timer (
    .clk(clk), .rst_n(rst_n), .reload_val(reload_val), .tick(tick)
  );

  rf_request_flag u_flag (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(done), .req(req)
  );

  rf_sequencer #(.TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .stagger_en(stagger_en),
    .ras_width(ras_width), .pre_time(pre_time), .st(st), .phase(phase),
    .stag_q(stag_q), .done(done)
  );

  rf_strobe_decode #(.NBANK(NBANK)) u_dec (
    .st(st), .phase(phase), .stag_q(stag_q),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );
endmodule

// File: rtl/cbr_refresh_chk.sv
`timescale 1ns/1ps
module cbr_refresh_chk #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             grant,
  input logic             xact_busy,
  input logic             req,
  input logic             busy,
  input logic             done,
  input logic [NBANK-1:0] ras_n,
  input logic [NBANK-1:0] cas_n
);
  // R4
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n != '1) |-> (cas_n == '0));

  // R4
  cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ras_n != '1) && ($past(ras_n) == '1)) |-> ($past(cas_n) == '0));

  // R3
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req && grant && !xact_busy));

  // R7
  done_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && (ras_n == '1) && (cas_n == '1)));

  // R7
  end_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  // R2
  req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> $past(done));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ((ras_n == '1) && (cas_n == '1) && !done));
endmodule

bind cbr_refresh_seq cbr_refresh_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .xact_busy(xact_busy),
  .req(req), .busy(busy), .done(done), .ras_n(ras_n), .cas_n(cas_n)
);

// File: tb/cbr_refresh_seq_test.sv
`timescale 1ns/1ps
module cbr_refresh_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reload_val = 16'd2000;
  logic        stagger_en = 1'b0;
  logic [3:0]  ras_width = 4'd4;
  logic [3:0]  pre_time = 4'd3;
  logic        xact_busy = 1'b0;
  logic        grant = 1'b0;
  logic        req, busy, done, we_n;
  logic [3:0]  ras_n, cas_n;

  int errs = 0;
  int total = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cbr_refresh_seq uut (
    .clk(clk), .rst_n(rst_n), .reload_val(reload_val), .stagger_en(stagger_en),
    .ras_width(ras_width), .pre_time(pre_time), .xact_busy(xact_busy),
    .grant(grant), .req(req), .busy(busy), .done(done),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_req();
    for (int i = 0; i < 5000 && !req; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R11: quiet outputs in reset
  task automatic t_reset_state();
    grant = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk({ras_n, cas_n, we_n, req, busy, done} == {8'hFF, 1'b1, 3'b000},
        "R11 reset state", {ras_n, cas_n, we_n, req, busy, done},
        {8'hFF, 1'b1, 3'b000});
    rst_n = 1'b1;
  endtask

  // R1 first tick timing, R2 request held without grant
  task automatic t_interval();
    int n;
    grant = 1'b0;
    reload_val = 16'd9;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!req && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == 10, "R1 edges to first request", n, 10);
    repeat (30) @(negedge clk);
    chk(req == 1'b1, "R2 request stays pending", req, 1);
    chk(busy == 1'b0, "R3 no start without grant", busy, 0);
  endtask

  // one full refresh, checked cycle by cycle
  task automatic t_seq(input bit stag, input int w, input int p,
                       input bit mid_change, input string scen);
    int we_, pe, nph;
    logic [3:0] ras_exp;
    reload_val = 16'd3;
    wait_req();
    reload_val = 16'd2000;
    stagger_en = stag;
    ras_width = 4'(w);
    pre_time = 4'(p);
    grant = 1'b1;
    we_ = (w == 0) ? 1 : w;
    pe  = (p == 0) ? 1 : p;
    nph = stag ? 2 : 1;
    for (int ph = 0; ph < nph; ph++) begin
      @(negedge clk);
      if (mid_change && ph == 0) begin
        stagger_en = ~stag;
        ras_width = 4'd9;
        pre_time = 4'd7;
      end
      chk({busy, ras_n, cas_n} == {1'b1, 4'hF, 4'h0},
          {"R4 lead cycle ", scen}, {busy, ras_n, cas_n}, {1'b1, 4'hF, 4'h0});
      ras_exp = !stag ? 4'b0000 : (ph == 0 ? 4'b1010 : 4'b0101);
      for (int k = 0; k < we_; k++) begin
        @(negedge clk);
        chk({busy, ras_n, cas_n} == {1'b1, ras_exp, 4'h0},
            {stag ? "R6 ras cycle " : "R5 ras cycle ", scen},
            {busy, ras_n, cas_n}, {1'b1, ras_exp, 4'h0});
        chk(we_n == 1'b1, {"R8 we held high ", scen}, we_n, 1);
      end
    end
    for (int k = 0; k < pe; k++) begin
      @(negedge clk);
      chk({busy, done, ras_n, cas_n} == {1'b1, k == pe - 1, 8'hFF},
          {"R7 precharge ", scen}, {busy, done, ras_n, cas_n},
          {1'b1, k == pe - 1, 8'hFF});
    end
    grant = 1'b0;
    @(negedge clk);
    chk({busy, req} == 2'b00, {"R2 request cleared ", scen}, {busy, req}, 0);
  endtask

  // R3: pending request waits for the transfer to end
  task automatic t_hold();
    reload_val = 16'd3;
    wait_req();
    reload_val = 16'd2000;
    stagger_en = 1'b0;
    ras_width = 4'd2;
    pre_time = 4'd2;
    xact_busy = 1'b1;
    grant = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk({busy, cas_n, ras_n} == {1'b0, 8'hFF}, "R3 held during transfer",
          {busy, cas_n, ras_n}, {1'b0, 8'hFF});
    end
    xact_busy = 1'b0;
    @(negedge clk);
    chk({busy, cas_n} == {1'b1, 4'h0}, "R3 starts after transfer",
        {busy, cas_n}, {1'b1, 4'h0});
    for (int i = 0; i < 20 && !done; i++) @(negedge clk);
    grant = 1'b0;
    @(negedge clk);
  endtask

  // R2: tick and completion on the same edge
  task automatic t_collide();
    grant = 1'b1;
    stagger_en = 1'b0;
    ras_width = 4'd4;
    pre_time = 4'd3;
    reload_val = 16'd8;
    do_reset();
    for (int i = 0; i < 100 && !done; i++) @(negedge clk);
    chk(done == 1'b1, "R7 done reached", done, 1);
    @(negedge clk);
    grant = 1'b0;
    chk({req, busy} == 2'b10, "R2 tick wins over clear", {req, busy}, 2'b10);
    reload_val = 16'd2000;
    @(negedge clk);
    chk(busy == 1'b0, "R3 no restart without grant", busy, 0);
  endtask

  // R11: reset in the middle of a refresh
  task automatic t_mid_reset();
    reload_val = 16'd3;
    wait_req();
    reload_val = 16'd2000;
    stagger_en = 1'b1;
    ras_width = 4'd4;
    grant = 1'b1;
    repeat (3) @(negedge clk);
    chk(ras_n == 4'b1010, "R6 mid refresh", ras_n, 4'b1010);
    rst_n = 1'b0;
    grant = 1'b0;
    #1;
    chk({ras_n, cas_n, we_n, req, busy, done} == {8'hFF, 1'b1, 3'b000},
        "R11 reset mid refresh", {ras_n, cas_n, we_n, req, busy, done},
        {8'hFF, 1'b1, 3'b000});
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset_state();
    t_interval();
    t_seq(1'b0, 4, 3, 1'b0, "simultaneous");
    t_seq(1'b1, 4, 3, 1'b0, "staggered");
    t_seq(1'b0, 0, 0, 1'b0, "R9 zero clamp");
    t_seq(1'b1, 1, 0, 1'b0, "R9 staggered clamp");
    t_seq(1'b0, 3, 2, 1'b1, "R10 change mid");
    t_hold();
    t_collide();
    t_mid_reset();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errs++;
      total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end
endmodule